// File: doc/BRIEF.md
# Multispeed data-strobe serial transceiver

The block sits between a link-side parallel data path and a two-wire data-strobe serial link, working in both directions. Everything runs on one fast clock at eight times the system rate; a phase counter inside the block produces a one-cycle system strobe, and every link-side transfer lines up with that strobe. At the lowest speed the link side moves 2 bits per system cycle, at the middle speed 4 and at the top speed 8. The serial bit cell therefore lasts 4, 2 or 1 fast cycles.

On the transmit side a word is taken on each system strobe while the send enable is high. It is shifted out most significant bit first and encoded so that exactly one of the two lines changes in every bit cell. On the receive side a new bit is detected whenever the XOR of the two incoming lines changes. The bits are packed into words of the width set by the receive speed, and each finished word is presented for exactly one system cycle. On both sides the speed is captured when a packet starts and is then held until the packet ends.

Top module: `dsx_transceiver`

## Requirements
- R1: After reset both transmit lines are low, `rx_valid_o` is low and `rx_data_o` is zero.
- R2: The speed code selects the word width: 2'b00 gives 2 bits, 2'b01 gives 4 bits, 2'b10 gives 8 bits, and 2'b11 is treated as 2 bits. A word occupies the low bits of `tx_data_i` and `rx_data_o`, and the unused high bits of `rx_data_o` read zero.
- R3: `sys_stb_o` is high for one fast cycle in every 8. While a packet is being sent, one transmit bit cell starts every 4, 2 or 1 fast cycles for widths 2, 4 and 8, so each system cycle carries exactly one word.
- R4: In every transmit bit cell exactly one of `tx_line_d_o` and `tx_line_s_o` changes. The data line carries the bit, and the strobe toggles when the bit equals the previous bit. When no bit is being sent, both lines hold their values.
- R5: Bit ordering: the transmitter sends the most significant bit of the word first, and the receiver places the first bit it receives in the most significant position of the word.
- R6: With `rx_en_i` high, each change of `rx_line_d_i` XOR `rx_line_s_i` delivers one bit, whose value is `rx_line_d_i`. Every complete group of width bits becomes one received word, and the words leave in the order their bits arrived.
- R7: `rx_valid_o` and `rx_data_o` change only on the fast edge that ends a cycle in which `sys_stb_o` is high. `rx_valid_o` is high for one system cycle per received word.
- R8: A word is accepted only on a system strobe with `tx_en_i` high. Speed codes are captured when a packet starts (first strobe with `tx_en_i` high; rising of `rx_en_i`), and any change to `tx_speed_i` or `rx_speed_i` during the packet has no effect.
- R9: While `tx_en_i` is low on every strobe, the transmit lines do not change.
- R10: Line transitions that arrive while `rx_en_i` is low produce no bits. When `rx_en_i` falls, any partially assembled word is discarded, and the next word starts with the first bit received after `rx_en_i` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, 8x system rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sys_stb_o | output | 1 | One-cycle system strobe, last fast cycle of each system cycle |
| tx_en_i | input | 1 | Send enable, sampled on the system strobe |
| tx_speed_i | input | 2 | Transmit speed code |
| tx_data_i | input | 8 | Transmit word, low bits used |
| tx_line_d_o | output | 1 | Encoded data line out |
| tx_line_s_o | output | 1 | Encoded strobe line out |
| rx_en_i | input | 1 | Receive enable; its rising edge starts a packet |
| rx_speed_i | input | 2 | Indicated receive speed code |
| rx_line_d_i | input | 1 | Incoming data line |
| rx_line_s_i | input | 1 | Incoming strobe line |
| rx_valid_o | output | 1 | Received word valid for one system cycle |
| rx_data_o | output | 8 | Received word, low bits used |

## Verification
The transmitter is looped back into the receiver at every speed code, including the reserved one. The loopback uses random, all-zero, all-one and alternating words. All-zero and all-one words make the strobe carry every transition, while alternating words keep it still, so the two halves of the encoding rule are tested separately. The bench decodes the transmit lines on its own to check transition counts, cell spacing and first-bit order. A packet that changes its speed inputs partway through shows whether the speed is latched. A hand-driven receive sequence with a mid-word disable, plus transitions that arrive while disabled, shows whether a partial word is dropped and whether disabled traffic is ignored.

// File: rtl/dsx_pkg.sv
package dsx_pkg;
  localparam int unsigned MAX_W = 8;
  localparam int unsigned RATIO = MAX_W;
  localparam int unsigned PH_W  = $clog2(RATIO);

  function automatic int unsigned spd_width(logic [1:0] s);
    case (s)
      2'b10:   return MAX_W;
      2'b01:   return MAX_W / 2;
      default: return MAX_W / 4;
    endcase
  endfunction

  function automatic logic [MAX_W-1:0] spd_mask(logic [1:0] s);
    logic [MAX_W-1:0] ones;
    ones = '1;
    return ones >> (MAX_W - spd_width(s));
  endfunction

  // bit cell starts every RATIO/width fast cycles
  function automatic logic bit_slot(logic [1:0] s, logic [PH_W-1:0] ph);
    int unsigned step;
    step = RATIO / spd_width(s);
    return (32'(ph) & (step - 1)) == 0;
  endfunction
endpackage

// File: rtl/dsx_timebase.sv
module dsx_timebase
  import dsx_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [PH_W-1:0] phase_o,
  output logic            sys_tick_o
);
  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else if (phase_q == PH_W'(RATIO - 1)) phase_q <= '0;
    else phase_q <= phase_q + 1'b1;
  end

  assign phase_o    = phase_q;
  assign sys_tick_o = (phase_q == PH_W'(RATIO - 1));

  a_r3_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_tick_o |=> !sys_tick_o);
endmodule

// File: rtl/dsx_tx.sv
module dsx_tx
  import dsx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PH_W-1:0]  phase_i,
  input  logic             sys_tick_i,
  input  logic             tx_en_i,
  input  logic [1:0]       speed_i,
  input  logic [MAX_W-1:0] data_i,
  output logic             line_d_o,
  output logic             line_s_o
);
  logic             act_q, shv_q, fire_q;
  logic [1:0]       spd_q;
  logic [MAX_W-1:0] sh_q;
  logic             d_q, s_q;
  logic [1:0]       load_spd;
  logic [MAX_W-1:0] sh_load;
  logic             fire, nbit;

  assign load_spd = act_q ? spd_q : speed_i;
  assign sh_load  = data_i << (MAX_W - spd_width(load_spd));
  assign fire     = shv_q && bit_slot(spd_q, phase_i);
  assign nbit     = sh_q[MAX_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      shv_q  <= 1'b0;
      fire_q <= 1'b0;
      spd_q  <= 2'b00;
      sh_q   <= '0;
      d_q    <= 1'b0;
      s_q    <= 1'b0;
    end else begin
      fire_q <= fire;
      if (fire) begin
        sh_q <= sh_q << 1;
        d_q  <= nbit;
        if (nbit == d_q) s_q <= ~s_q;
      end
      if (sys_tick_i) begin
        act_q <= tx_en_i;
        shv_q <= tx_en_i;
        if (!act_q) spd_q <= speed_i;
        if (tx_en_i) sh_q <= sh_load;
      end
    end
  end

  assign line_d_o = d_q;
  assign line_s_o = s_q;

  a_r4_one_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_q |-> $countones({d_q ^ $past(d_q), s_q ^ $past(s_q)}) == 1);
  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_q |-> ($stable(d_q) && $stable(s_q)));
  a_r8_tx_spd_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && $past(act_q)) |-> $stable(spd_q));
endmodule

// File: rtl/dsx_rx.sv
module dsx_rx
  import dsx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sys_tick_i,
  input  logic             rx_en_i,
  input  logic [1:0]       speed_i,
  input  logic             line_d_i,
  input  logic             line_s_i,
  output logic             valid_o,
  output logic [MAX_W-1:0] data_o
);
  localparam int unsigned CW = $clog2(MAX_W + 1);

  logic             cap_d, cap_s, par_q;
  logic [1:0]       spd_q;
  logic [CW-1:0]    cnt_q, cnt_next;
  logic [MAX_W-1:0] acc_q, acc_next, hold_q;
  logic             pend_q;
  logic             take, done;

  assign take     = rx_en_i && ((cap_d ^ cap_s) != par_q);
  assign acc_next = {acc_q[MAX_W-2:0], cap_d};
  assign cnt_next = cnt_q + 1'b1;
  assign done     = take && (cnt_next == CW'(spd_width(spd_q)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_d  <= 1'b0;
      cap_s  <= 1'b0;
      par_q  <= 1'b0;
      spd_q  <= 2'b00;
      cnt_q  <= '0;
      acc_q  <= '0;
      hold_q <= '0;
      pend_q <= 1'b0;
    end else begin
      cap_d <= line_d_i;
      cap_s <= line_s_i;
      par_q <= cap_d ^ cap_s;
      if (!rx_en_i) spd_q <= speed_i;
      if (!rx_en_i || done) begin
        cnt_q <= '0;
        acc_q <= '0;
      end else if (take) begin
        cnt_q <= cnt_next;
        acc_q <= acc_next;
      end
      if (done) hold_q <= acc_next & spd_mask(spd_q);
      if (sys_tick_i) pend_q <= done;
      else if (done) pend_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (sys_tick_i) begin
      valid_o <= pend_q;
      data_o  <= pend_q ? hold_q : '0;
    end
  end

  a_r7_out_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sys_tick_i) |-> ($stable(valid_o) && $stable(data_o)));
  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) < spd_width(spd_q));
  a_r10_idle_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rx_en_i) |-> (cnt_q == '0));
endmodule

// File: rtl/dsx_transceiver.sv
module dsx_transceiver
  import dsx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             sys_stb_o,
  input  logic             tx_en_i,
  input  logic [1:0]       tx_speed_i,
  input  logic [MAX_W-1:0] tx_data_i,
  output logic             tx_line_d_o,
  output logic             tx_line_s_o,
  input  logic             rx_en_i,
  input  logic [1:0]       rx_speed_i,
  input  logic             rx_line_d_i,
  input  logic             rx_line_s_i,
  output logic             rx_valid_o,
  output logic [MAX_W-1:0] rx_data_o
);
  logic [PH_W-1:0] phase;
  logic            tick;

  dsx_timebase u_tb (
    .clk_i, .rst_ni, .phase_o(phase), .sys_tick_o(tick)
  );

  dsx_tx u_tx (
    .clk_i, .rst_ni, .phase_i(phase), .sys_tick_i(tick),
    .tx_en_i, .speed_i(tx_speed_i), .data_i(tx_data_i),
    .line_d_o(tx_line_d_o), .line_s_o(tx_line_s_o)
  );

  dsx_rx u_rx (
    .clk_i, .rst_ni, .sys_tick_i(tick),
    .rx_en_i, .speed_i(rx_speed_i),
    .line_d_i(rx_line_d_i), .line_s_i(rx_line_s_i),
    .valid_o(rx_valid_o), .data_o(rx_data_o)
  );

  assign sys_stb_o = tick;
endmodule

// File: tb/dsx_transceiver_tb_top.sv
module dsx_transceiver_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sys_stb, tx_en = 0, tx_d, tx_s, rx_en = 0, rx_valid;
  logic [1:0] tx_speed = 0, rx_speed = 0;
  logic [7:0] tx_data = 0, rx_data;
  logic       man_mode = 0, man_d = 0, man_s = 0;
  logic       rx_d, rx_s;

  assign rx_d = man_mode ? man_d : tx_d;
  assign rx_s = man_mode ? man_s : tx_s;

  dsx_transceiver dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sys_stb_o(sys_stb),
    .tx_en_i(tx_en), .tx_speed_i(tx_speed), .tx_data_i(tx_data),
    .tx_line_d_o(tx_d), .tx_line_s_o(tx_s),
    .rx_en_i(rx_en), .rx_speed_i(rx_speed),
    .rx_line_d_i(rx_d), .rx_line_s_i(rx_s),
    .rx_valid_o(rx_valid), .rx_data_o(rx_data)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wid(logic [1:0] s);
    return (s == 2'b10) ? 8 : (s == 2'b01) ? 4 : 2;
  endfunction

  // line monitor: independent decode of the transmit lines
  logic pd = 0, ps = 0, seen = 0;
  int chg = 0, both_err = 0, first_c = 0, last_c = 0;
  logic [7:0] dec = 0;
  always @(negedge clk) if (rst_n) begin
    if (tx_d != pd && tx_s != ps) both_err++;
    if (tx_d != pd || tx_s != ps) begin
      chg++;
      dec = {dec[6:0], tx_d};
      if (!seen) first_c = cyc;
      last_c = cyc;
      seen = 1;
    end
    pd = tx_d;
    ps = tx_s;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n && sys_stb && rx_valid) begin
    if (exp_q.size() == 0) chk(0, "R6 unexpected word", rx_data, 0);
    else begin
      logic [7:0] e;
      e = exp_q.pop_front();
      chk(rx_data == e, "R2 R6 received word", rx_data, e);
    end
  end

  task automatic wait_stb();
    @(negedge clk);
    while (!sys_stb) @(negedge clk);
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (24) @(negedge clk);
    chk(exp_q.size() == 0, "R6 words outstanding", exp_q.size(), 0);
  endtask

  task automatic send_pkt(logic [1:0] spd, int n, bit chg_spd, bit rnd, logic [7:0] val);
    int w, c0, step;
    w = wid(spd);
    step = 8 / w;
    rx_en = 0;
    rx_speed = spd;
    @(negedge clk);
    rx_en = 1;
    c0 = chg;
    seen = 0;
    wait_stb();
    tx_speed = spd;
    tx_en = 1;
    for (int i = 0; i < n; i++) begin
      if (i > 0) wait_stb();
      tx_data = rnd ? 8'($urandom) : val;
      if (i == 1 && chg_spd) begin
        tx_speed = ~spd;
        rx_speed = ~spd;
      end
      exp_q.push_back(tx_data & 8'((1 << w) - 1));
    end
    wait_stb();
    tx_en = 0;
    tx_data = 0;
    drain();
    chk(chg - c0 == n * w, "R4 transitions per packet", chg - c0, n * w);
    chk(last_c - first_c == (n * w - 1) * step, "R3 bit cell spacing",
        last_c - first_c, (n * w - 1) * step);
    chk(both_err == 0, "R4 both lines changed", both_err, 0);
    rx_en = 0;
  endtask

  task automatic man_bit(logic b);
    @(negedge clk);
    if (b == man_d) man_s = ~man_s;
    else man_d = b;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int t0, c0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_d == 0 && tx_s == 0, "R1 lines after reset", {tx_d, tx_s}, 0);
    chk(rx_valid == 0 && rx_data == 0, "R1 rx outputs after reset", {rx_valid, rx_data}, 0);

    wait_stb(); t0 = cyc;
    wait_stb();
    chk(cyc - t0 == 8, "R3 strobe period", cyc - t0, 8);
    wait_stb();
    chk(cyc - t0 == 16, "R3 strobe period", cyc - t0, 16);

    c0 = chg;
    repeat (5) wait_stb();
    chk(chg == c0, "R9 idle lines", chg - c0, 0);

    send_pkt(2'b00, 6, 0, 1, 0);
    send_pkt(2'b01, 6, 0, 1, 0);
    send_pkt(2'b10, 8, 0, 1, 0);
    send_pkt(2'b11, 4, 0, 1, 0);
    send_pkt(2'b10, 4, 0, 0, 8'h00);
    send_pkt(2'b01, 4, 0, 0, 8'h0F);
    send_pkt(2'b10, 4, 0, 0, 8'hAA);
    send_pkt(2'b10, 6, 1, 1, 0);
    send_pkt(2'b00, 5, 1, 1, 0);

    send_pkt(2'b01, 1, 0, 0, 8'h08);
    chk(dec[3:0] == 4'h8, "R5 tx bit order", dec[3:0], 8);
    send_pkt(2'b10, 1, 0, 0, 8'hF9);
    chk(dec == 8'hF9, "R5 tx bit order", dec, 8'hF9);

    // hand-driven receive sequence
    repeat (8) @(negedge clk);
    man_d = tx_d;
    man_s = tx_s;
    man_mode = 1;
    rx_speed = 2'b01;
    @(negedge clk);
    rx_en = 1;
    man_bit(1); man_bit(1);
    repeat (4) @(negedge clk);
    rx_en = 0;
    repeat (4) @(negedge clk);
    man_bit(0); man_bit(1); man_bit(0);
    repeat (4) @(negedge clk);
    rx_en = 1;
    exp_q.push_back(8'h08);
    man_bit(1); man_bit(0); man_bit(0); man_bit(0);
    drain();
    chk(1, "R10 partial word dropped", 0, 0);
    rx_en = 0;
    man_mode = 0;

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule